// File: doc/BRIEF.md
# Framebuffer Controller Register Bank with Frame Interrupt

This block is the byte-wide control and status register bank of a framebuffer controller. A host bus reads and writes single bytes through a small address space. The bank owns sixteen consecutive offsets:

- a control byte whose top bit enables the frame interrupt,
- a status byte,
- fourteen plain storage bytes.

The lower part of the address space belongs to other blocks. This bank reads zero there and ignores writes there.

The video timing logic gives a one-cycle end-of-frame pulse. When interrupts are enabled, that pulse sets a sticky pending flag and raises a level interrupt line. The status byte returns the pending flag in its top bit, merged with hardwired identification bits for monitor sense and board type. Software acknowledges the interrupt by writing anything to the status offset. If an acknowledge and a new frame pulse land in the same cycle, the new frame wins.

Read data comes out either directly from the address or one clock after it, as chosen by a parameter. Reads have no side effects.

Top module: `fbc_regbank`

## Requirements
- R1: After reset the interrupt line is low, the control byte reads 0x00, the storage bytes read 0x00, and the status byte reads 0x61.
- R2: The control byte at offset 0x10 stores all eight written bits and reads them back unchanged.
- R3: The status byte at offset 0x11 reads as bit 7 = pending flag, bits 6 and 5 = 1 (monitor sense), bit 0 = 1 (color board), and all other bits 0. The value is therefore 0x61 when idle and 0xE1 when pending.
- R4: An end-of-frame pulse while control bit 7 is 1 sets the pending flag and drives the interrupt line high on the next clock. Both stay high until an acknowledge.
- R5: An end-of-frame pulse while control bit 7 is 0 leaves the pending flag and the interrupt line unchanged.
- R6: Any write to offset 0x11 clears the pending flag and lowers the interrupt line on the next clock. The written data is not stored.
- R7: When a write to offset 0x11 and an enabled end-of-frame pulse occur in the same cycle, the flag and the line end up set.
- R8: Offsets 0x12 to 0x1F are independent 8-bit read/write registers.
- R9: Reads of offsets 0x00 to 0x0F return 0x00, and writes there change no register.
- R10: With the one-cycle read option, the read data shows the register selected by the address sampled at the previous clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W (5) | Byte offset of the access |
| bus_wr | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | DATA_W (8) | Write data |
| bus_rdata | output | DATA_W (8) | Read data for bus_addr |
| frame_end | input | 1 | One-cycle end-of-frame pulse |
| irq | output | 1 | Level frame interrupt |

## Verification
The bench builds the bank with its default parameters:

- a 5-bit address,
- 8-bit data,
- the window at 0x10,
- the identification value 0x61,
- the registered read option.

This selects the one-cycle read path, so a read task that waits a whole cycle observes every register through the bus. A sample taken before the edge shows the read delay directly. The narrow address reaches every offset, including all sixteen foreign offsets below the window. The directed scenarios order frame pulses, acknowledges and enable changes so that the set-versus-clear collision and the sticky hold are each isolated.

// File: rtl/fbc_regbank_pkg.sv
package fbc_regbank_pkg;

   // Register roles inside the owned window
   typedef enum logic [1:0] {
      SEL_NONE = 2'd0,
      SEL_CTRL = 2'd1,
      SEL_STAT = 2'd2,
      SEL_GP   = 2'd3
   } fbc_sel_e;

   localparam int unsigned CTRL_REL = 0;
   localparam int unsigned STAT_REL = 1;
   localparam int unsigned GP_REL   = 2;

   // Map an absolute byte offset to the register role it addresses
   function automatic fbc_sel_e fbc_classify(input int unsigned a,
                                             input int unsigned base,
                                             input int unsigned size);
      if (a < base || a >= base + size) return SEL_NONE;
      if (a == base + CTRL_REL)         return SEL_CTRL;
      if (a == base + STAT_REL)         return SEL_STAT;
      return SEL_GP;
   endfunction

endpackage

// File: rtl/fbc_ctrl_reg.sv
module fbc_ctrl_reg #(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [DATA_W-1:0] wdata,
   output logic [DATA_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= wdata;
   end
endmodule

// File: rtl/fbc_pend_irq.sv
module fbc_pend_irq (
   input  logic clk,
   input  logic rst_n,
   input  logic frame_end,
   input  logic int_en,
   input  logic ack_we,
   output logic pend,
   output logic irq
);
   logic pend_q;

   // The set term is tested first, so a frame event beats a same-cycle acknowledge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                   pend_q <= 1'b0;
      else if (frame_end && int_en) pend_q <= 1'b1;
      else if (ack_we)              pend_q <= 1'b0;
   end

   assign pend = pend_q;
   assign irq  = pend_q;
endmodule

// File: rtl/fbc_gp_bank.sv
module fbc_gp_bank #(
   parameter int DATA_W = 8,
   parameter int NUM    = 14,
   localparam int IDX_W = (NUM > 1) ? $clog2(NUM) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [IDX_W-1:0]  wr_idx,
   input  logic [DATA_W-1:0] wdata,
   input  logic [IDX_W-1:0]  rd_idx,
   output logic [DATA_W-1:0] rdata
);
   logic [DATA_W-1:0] store [NUM];

   for (genvar g = 0; g < NUM; g++) begin : g_byte
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                                    store[g] <= '0;
         else if (we && (wr_idx == IDX_W'(g)))          store[g] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int k = 0; k < NUM; k++) begin
         if (rd_idx == IDX_W'(k)) rdata = store[k];
      end
   end
endmodule

// File: rtl/fbc_rd_port.sv
module fbc_rd_port #(
   parameter int DATA_W  = 8,
   parameter int LATENCY = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout
);
   if (LATENCY == 0) begin : g_comb
      assign dout = din;
   end else begin : g_flop
      logic [DATA_W-1:0] hold_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) hold_q <= '0;
         else        hold_q <= din;
      end
      assign dout = hold_q;
   end
endmodule

// File: rtl/fbc_regbank.sv
module fbc_regbank
   import fbc_regbank_pkg::*;
#(
   parameter int          ADDR_W       = 5,
   parameter int          DATA_W       = 8,
   parameter int          WIN_BASE     = 16,
   parameter int          WIN_SIZE     = 16,
   parameter int          IEN_BIT      = 7,
   parameter int          PEND_BIT     = 7,
   parameter logic [7:0]  STATUS_ID    = 8'h61,
   parameter int          READ_LATENCY = 1,
   localparam int         NUM_GP       = WIN_SIZE - 2,
   localparam int         GP_IDX_W     = (NUM_GP > 1) ? $clog2(NUM_GP) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_wr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              frame_end,
   output logic              irq
);
   // Parameter sanity
   initial begin
      assert (DATA_W >= 8)
         else $error("fbc_regbank: DATA_W must be at least 8");
      assert (WIN_SIZE >= 3)
         else $error("fbc_regbank: window needs control, status and storage");
      assert (WIN_BASE + WIN_SIZE <= (1 << ADDR_W))
         else $error("fbc_regbank: window exceeds address space");
      assert (IEN_BIT < DATA_W && PEND_BIT < DATA_W)
         else $error("fbc_regbank: flag bit outside data width");
      assert (STATUS_ID[PEND_BIT] == 1'b0)
         else $error("fbc_regbank: id bits collide with pending flag");
      assert (READ_LATENCY == 0 || READ_LATENCY == 1)
         else $error("fbc_regbank: READ_LATENCY must be 0 or 1");
   end

   fbc_sel_e            sel;
   logic [GP_IDX_W-1:0] gp_idx;
   logic [DATA_W-1:0]   ctrl_q;
   logic [DATA_W-1:0]   gp_rdata;
   logic [DATA_W-1:0]   rd_mux;
   logic                pend;

   assign sel    = fbc_classify(32'(bus_addr), WIN_BASE, WIN_SIZE);
   assign gp_idx = GP_IDX_W'(32'(bus_addr) - WIN_BASE - GP_REL);

   fbc_ctrl_reg #(.DATA_W(DATA_W)) u_ctrl (
      .clk   (clk),
      .rst_n (rst_n),
      .we    (bus_wr && (sel == SEL_CTRL)),
      .wdata (bus_wdata),
      .q     (ctrl_q)
   );

   fbc_pend_irq u_pend (
      .clk       (clk),
      .rst_n     (rst_n),
      .frame_end (frame_end),
      .int_en    (ctrl_q[IEN_BIT]),
      .ack_we    (bus_wr && (sel == SEL_STAT)),
      .pend      (pend),
      .irq       (irq)
   );

   fbc_gp_bank #(.DATA_W(DATA_W), .NUM(NUM_GP)) u_gp (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (bus_wr && (sel == SEL_GP)),
      .wr_idx (gp_idx),
      .wdata  (bus_wdata),
      .rd_idx (gp_idx),
      .rdata  (gp_rdata)
   );

   always_comb begin
      unique case (sel)
         SEL_CTRL: rd_mux = ctrl_q;
         SEL_STAT: begin
            rd_mux           = DATA_W'(STATUS_ID);
            rd_mux[PEND_BIT] = pend;
         end
         SEL_GP:   rd_mux = gp_rdata;
         default:  rd_mux = '0;
      endcase
   end

   fbc_rd_port #(.DATA_W(DATA_W), .LATENCY(READ_LATENCY)) u_rd (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (rd_mux),
      .dout  (bus_rdata)
   );
endmodule

// File: rtl/fbc_regbank_chk.sv
module fbc_regbank_chk #(
   parameter int ADDR_W   = 5,
   parameter int DATA_W   = 8,
   parameter int WIN_BASE = 16,
   parameter int IEN_BIT  = 7
) (
   input logic              clk,
   input logic              rst_n,
   input logic [ADDR_W-1:0] bus_addr,
   input logic              bus_wr,
   input logic [DATA_W-1:0] bus_wdata,
   input logic              frame_end,
   input logic              irq,
   input logic [DATA_W-1:0] ctrl_q
);
   logic ctl_wr, ack_wr, fire;
   assign ctl_wr = bus_wr && (32'(bus_addr) == WIN_BASE);
   assign ack_wr = bus_wr && (32'(bus_addr) == WIN_BASE + 1);
   assign fire   = frame_end && ctrl_q[IEN_BIT];

   // R1
   rst_irq_chk: assert property (@(posedge clk) !rst_n |-> !irq);

   // R2
   ctrl_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ctl_wr |=> ctrl_q == $past(bus_wdata));

   // R9
   ctrl_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !ctl_wr |=> $stable(ctrl_q));

   // R4
   irq_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fire |=> irq);

   // R4
   irq_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (irq && !ack_wr) |=> irq);

   // R5
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!irq && !fire) |=> !irq);

   // R6
   irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && !fire) |=> !irq);

   // R7
   set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_wr && fire) |=> irq);
endmodule

bind fbc_regbank fbc_regbank_chk #(
   .ADDR_W   (ADDR_W),
   .DATA_W   (DATA_W),
   .WIN_BASE (WIN_BASE),
   .IEN_BIT  (IEN_BIT)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .bus_addr  (bus_addr),
   .bus_wr    (bus_wr),
   .bus_wdata (bus_wdata),
   .frame_end (frame_end),
   .irq       (irq),
   .ctrl_q    (ctrl_q)
);

// File: tb/fbc_regbank_tb.sv
`timescale 1ns/1ps
module fbc_regbank_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [4:0] bus_addr = '0;
   logic       bus_wr = 1'b0;
   logic [7:0] bus_wdata = '0;
   logic [7:0] bus_rdata;
   logic       frame_end = 1'b0;
   logic       irq;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;   // 50 MHz

   fbc_regbank u_dut (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_addr  (bus_addr),
      .bus_wr    (bus_wr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .frame_end (frame_end),
      .irq       (irq)
   );

   task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: got 0x%02h expected 0x%02h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [7:0] d);
      @(negedge clk);
      bus_addr = a; bus_wr = 1'b0;
      @(negedge clk);
      d = bus_rdata;
   endtask

   task automatic pulse_frame();
      @(negedge clk);
      frame_end = 1'b1;
      @(negedge clk);
      frame_end = 1'b0;
   endtask

   task automatic t_reset();
      logic [7:0] v;
      check("R1 irq", {7'b0, irq}, 8'h00);
      rd(5'h10, v); check("R1 ctrl", v, 8'h00);
      rd(5'h11, v); check("R1 status", v, 8'h61);
      rd(5'h15, v); check("R1 storage", v, 8'h00);
   endtask

   task automatic t_ctrl();
      logic [7:0] v;
      wr(5'h10, 8'hA5); rd(5'h10, v); check("R2 ctrl A5", v, 8'hA5);
      wr(5'h10, 8'h5A); rd(5'h10, v); check("R2 ctrl 5A", v, 8'h5A);
      rd(5'h11, v); check("R3 status idle", v, 8'h61);
      wr(5'h10, 8'h00);
   endtask

   task automatic t_disabled_frame();
      logic [7:0] v;
      wr(5'h10, 8'h7F);
      pulse_frame();
      check("R5 irq", {7'b0, irq}, 8'h00);
      rd(5'h11, v); check("R5 status", v, 8'h61);
   endtask

   task automatic t_enabled_frame();
      logic [7:0] v;
      wr(5'h10, 8'h80);
      pulse_frame();
      check("R4 irq set", {7'b0, irq}, 8'h01);
      rd(5'h11, v); check("R3 status pending", v, 8'hE1);
      repeat (3) @(negedge clk);
      check("R4 irq sticky", {7'b0, irq}, 8'h01);
      wr(5'h10, 8'h00);
      pulse_frame();
      check("R5 pending kept", {7'b0, irq}, 8'h01);
      wr(5'h11, 8'h00);
      check("R6 irq cleared", {7'b0, irq}, 8'h00);
      rd(5'h11, v); check("R6 status cleared", v, 8'h61);
   endtask

   task automatic t_ack_data_ignored();
      logic [7:0] v;
      wr(5'h11, 8'hFF);
      rd(5'h11, v); check("R6 data not stored", v, 8'h61);
      check("R6 irq stays low", {7'b0, irq}, 8'h00);
   endtask

   task automatic t_collision();
      logic [7:0] v;
      wr(5'h10, 8'h80);
      pulse_frame();
      @(negedge clk);
      bus_addr = 5'h11; bus_wdata = 8'h80; bus_wr = 1'b1; frame_end = 1'b1;
      @(negedge clk);
      bus_wr = 1'b0; frame_end = 1'b0;
      check("R7 set wins irq", {7'b0, irq}, 8'h01);
      rd(5'h11, v); check("R7 set wins status", v, 8'hE1);
      wr(5'h11, 8'h00);
      check("R7 later ack", {7'b0, irq}, 8'h00);
      wr(5'h10, 8'h00);
   endtask

   task automatic t_storage();
      logic [7:0] v;
      for (int a = 8'h12; a <= 8'h1F; a++) wr(5'(a), 8'(a * 7 + 3));
      for (int a = 8'h12; a <= 8'h1F; a++) begin
         rd(5'(a), v);
         check($sformatf("R8 byte %0h", a), v, 8'(a * 7 + 3));
      end
   endtask

   task automatic t_foreign();
      logic [7:0] v;
      wr(5'h10, 8'h3C);
      for (int a = 0; a < 16; a++) wr(5'(a), 8'hAA);
      for (int a = 0; a < 16; a++) begin
         rd(5'(a), v);
         check($sformatf("R9 read zero %0h", a), v, 8'h00);
      end
      rd(5'h10, v); check("R9 ctrl untouched", v, 8'h3C);
      rd(5'h12, v); check("R9 storage untouched", v, 8'(8'h12 * 7 + 3));
      rd(5'h11, v); check("R9 status untouched", v, 8'h61);
      check("R9 irq untouched", {7'b0, irq}, 8'h00);
      wr(5'h10, 8'h00);
   endtask

   task automatic t_latency();
      logic [7:0] v;
      wr(5'h13, 8'h11);
      wr(5'h14, 8'h22);
      rd(5'h13, v); check("R10 first", v, 8'h11);
      @(negedge clk);
      bus_addr = 5'h14;
      #5;
      check("R10 before edge", bus_rdata, 8'h11);
      @(negedge clk);
      check("R10 after edge", bus_rdata, 8'h22);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ctrl();
      t_disabled_frame();
      t_enabled_frame();
      t_ack_data_ignored();
      t_collision();
      t_storage();
      t_foreign();
      t_latency();
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule